// File: doc/BRIEF.md
# Trap and Exception-Return Program Counter Unit

This block owns the program counter of a small in-order core and the single register that remembers where to resume after a software trap. Every cycle it receives an already decoded instruction class, a valid flag, a stall flag and the 26-bit jump field of the instruction. From these it computes the address of the next instruction and updates its two registers. The PC register and the interrupt address register (IAR) are both visible on the ports.

Ordinary instructions and no-operations step the PC by one instruction word. A trap sends control to an absolute target. That target is the 26-bit field padded with zeros above it, so it is never sign-extended and never added to the PC. The trap also records PC+8 in the IAR, which places the return point past the delay slot. A return-from-exception copies the IAR into the PC. Stalled or invalid cycles change nothing.

The reset pin is asserted asynchronously and active low. An internal two-stage synchronizer releases it on the clock.

Top module: `trap_pc_unit`

## Requirements
- R1: With `op_i` = 2'b00 (sequential) or 2'b01 (no-operation) on an enabled cycle, the PC becomes PC+4, modulo 2^32.
- R2: With `op_i` = 2'b10 (trap) on an enabled cycle, the PC becomes the 26-bit `jfield_i` zero-extended to 32 bits. The top 6 bits of `pc_o` are zero whatever `jfield_i[25]` is.
- R3: On an enabled trap, the IAR receives the PC of that cycle plus 8, modulo 2^32.
- R4: With `op_i` = 2'b11 (return from exception) on an enabled cycle, the PC becomes the current IAR value, and the IAR is left unchanged.
- R5: The IAR changes only on an enabled trap. Sequential, no-operation and return cycles leave it as it was.
- R6: A cycle is enabled only when `valid_i` = 1 and `stall_i` = 0. On any other cycle the PC and the IAR both hold, whatever `op_i` and `jfield_i` carry.
- R7: While `rst_ni` is low, `pc_o` and `iar_o` are zero. After `rst_ni` rises, the first two rising clock edges still hold this reset state.
- R8: `next_pc_o` is combinational. It always equals the value `pc_o` will take at the next rising edge, for the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| valid_i | input | 1 | The instruction class on `op_i` is valid this cycle |
| stall_i | input | 1 | Holds all state this cycle |
| op_i | input | 2 | Instruction class: 00 sequential, 01 no-operation, 10 trap, 11 return from exception |
| jfield_i | input | 26 | Jump field of the current instruction |
| pc_o | output | 32 | Current program counter |
| iar_o | output | 32 | Interrupt address register |
| next_pc_o | output | 32 | PC value after the coming edge |

## Verification
The PC and the IAR drive `pc_o` and `iar_o` directly, so a wrong register value appears on the ports one edge after the faulty update. A wrong selection shows on `next_pc_o` in the same cycle. Some faults stay hidden until later. A corrupted IAR does not show on the PC until the next return-from-exception, but it is visible on `iar_o` at once, and the bench compares `iar_o` every cycle. The sweep places the top bit of the jump field in both states, which catches a sign extension in the trap target. It also follows traps with returns, which exposes a wrong return offset or a return that writes the IAR.

// File: rtl/trap_pc_pkg.sv
package trap_pc_pkg;

  // Decoded instruction classes handled by the PC unit
  typedef enum logic [1:0] {
    PC_OP_SEQ  = 2'b00,
    PC_OP_NOP  = 2'b01,
    PC_OP_TRAP = 2'b10,
    PC_OP_RFE  = 2'b11
  } pc_op_e;

  // Update request produced by the selection logic
  typedef struct packed {
    logic pc_en;
    logic iar_en;
  } pc_upd_t;

endpackage

// File: rtl/trap_pc_rst_sync.sv
module trap_pc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/trap_pc_next_sel.sv
module trap_pc_next_sel
  import trap_pc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int JFIELD_W   = 26,
  parameter int INSN_BYTES = 4,
  parameter int RET_OFFSET = 8
) (
  input  logic                valid_i,
  input  logic                stall_i,
  input  pc_op_e              op_i,
  input  logic [JFIELD_W-1:0] jfield_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic [XLEN-1:0]     iar_i,
  output logic [XLEN-1:0]     pc_nxt_o,
  output logic [XLEN-1:0]     iar_nxt_o,
  output pc_upd_t             upd_o
);

  localparam logic [XLEN-1:0] STEP    = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] RET_ADD = XLEN'(RET_OFFSET);

  logic            advance;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] ret_addr;
  logic [XLEN-1:0] trap_tgt;

  // Absolute trap target: field padded with zeros, never sign-extended
  generate
    if (JFIELD_W < XLEN) begin : g_pad
      always_comb trap_tgt = {{(XLEN-JFIELD_W){1'b0}}, jfield_i};
    end else begin : g_trunc
      always_comb trap_tgt = jfield_i[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    advance  = valid_i && !stall_i;
    seq_pc   = pc_i + STEP;
    ret_addr = pc_i + RET_ADD;
  end

  always_comb begin
    pc_nxt_o     = pc_i;
    iar_nxt_o    = iar_i;
    upd_o.pc_en  = 1'b0;
    upd_o.iar_en = 1'b0;
    if (advance) begin
      upd_o.pc_en = 1'b1;
      unique case (op_i)
        PC_OP_SEQ,
        PC_OP_NOP: pc_nxt_o = seq_pc;
        PC_OP_TRAP: begin
          pc_nxt_o     = trap_tgt;
          iar_nxt_o    = ret_addr;
          upd_o.iar_en = 1'b1;
        end
        PC_OP_RFE:  pc_nxt_o = iar_i;
        default:    pc_nxt_o = seq_pc;
      endcase
    end
  end

endmodule

// File: rtl/trap_pc_iar_reg.sv
module trap_pc_iar_reg #(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] q_o
);

  logic [XLEN-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= RESET_VAL;
    end else if (en_i) begin
      q <= d_i;
    end
  end

  assign q_o = q;

endmodule

// File: rtl/trap_pc_unit.sv
module trap_pc_unit
  import trap_pc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              JFIELD_W   = 26,
  parameter int              INSN_BYTES = 4,
  parameter int              RET_OFFSET = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [XLEN-1:0] RESET_PC   = '0,
  parameter logic [XLEN-1:0] RESET_IAR  = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                stall_i,
  input  logic [1:0]          op_i,
  input  logic [JFIELD_W-1:0] jfield_i,
  output logic [XLEN-1:0]     pc_o,
  output logic [XLEN-1:0]     iar_o,
  output logic [XLEN-1:0]     next_pc_o
);

  logic            rst_sync_n;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] iar_q;
  logic [XLEN-1:0] pc_nxt;
  logic [XLEN-1:0] iar_nxt;
  pc_upd_t         upd;
  pc_op_e          op;

  assign op = pc_op_e'(op_i);

  trap_pc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  trap_pc_next_sel #(
    .XLEN       (XLEN),
    .JFIELD_W   (JFIELD_W),
    .INSN_BYTES (INSN_BYTES),
    .RET_OFFSET (RET_OFFSET)
  ) u_next_sel (
    .valid_i   (valid_i),
    .stall_i   (stall_i),
    .op_i      (op),
    .jfield_i  (jfield_i),
    .pc_i      (pc_q),
    .iar_i     (iar_q),
    .pc_nxt_o  (pc_nxt),
    .iar_nxt_o (iar_nxt),
    .upd_o     (upd)
  );

  // Program counter register
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= RESET_PC;
    end else if (upd.pc_en) begin
      pc_q <= pc_nxt;
    end
  end

  trap_pc_iar_reg #(
    .XLEN      (XLEN),
    .RESET_VAL (RESET_IAR)
  ) u_iar (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (upd.iar_en),
    .d_i    (iar_nxt),
    .q_o    (iar_q)
  );

  assign pc_o      = pc_q;
  assign iar_o     = iar_q;
  assign next_pc_o = pc_nxt;

endmodule

// File: rtl/trap_pc_unit_chk.sv
module trap_pc_unit_chk #(
  parameter int XLEN       = 32,
  parameter int JFIELD_W   = 26,
  parameter int INSN_BYTES = 4,
  parameter int RET_OFFSET = 8
) (
  input logic                clk_i,
  input logic                rst_sync_n,
  input logic                valid_i,
  input logic                stall_i,
  input logic [1:0]          op_i,
  input logic [JFIELD_W-1:0] jfield_i,
  input logic [XLEN-1:0]     pc_o,
  input logic [XLEN-1:0]     iar_o
);

  logic fire;
  assign fire = valid_i && !stall_i;

  // R1: sequential and no-operation classes step by one word
  p_seq_step_r1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (fire && !op_i[1]) |=> (pc_o == $past(pc_o) + XLEN'(INSN_BYTES)));

  // R2: trap target is the zero-padded field
  p_trap_target_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (fire && op_i == 2'b10) |=> (pc_o == XLEN'($past(jfield_i))));

  // R3: trap saves the return point past the delay slot
  p_trap_ret_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (fire && op_i == 2'b10) |=> (iar_o == $past(pc_o) + XLEN'(RET_OFFSET)));

  // R4: return restores the PC from the IAR
  p_rfe_pc_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (fire && op_i == 2'b11) |=> (pc_o == $past(iar_o)));

  // R5: IAR is written by traps only
  p_iar_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(fire && op_i == 2'b10) |=> $stable(iar_o));

  // R6: disabled cycles hold the PC
  p_pc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !fire |=> $stable(pc_o));

  // R7: held reset keeps both registers cleared
  p_reset_state_r7: assert property (@(posedge clk_i)
    !rst_sync_n |-> (pc_o == '0 && iar_o == '0));

endmodule

bind trap_pc_unit trap_pc_unit_chk #(
  .XLEN       (XLEN),
  .JFIELD_W   (JFIELD_W),
  .INSN_BYTES (INSN_BYTES),
  .RET_OFFSET (RET_OFFSET)
) u_chk (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .valid_i    (valid_i),
  .stall_i    (stall_i),
  .op_i       (op_i),
  .jfield_i   (jfield_i),
  .pc_o       (pc_o),
  .iar_o      (iar_o)
);

// File: tb/trap_pc_unit_bench.sv
`timescale 1ns/1ps
module trap_pc_unit_bench;

  logic        clk_i;
  logic        rst_ni;
  logic        valid_i;
  logic        stall_i;
  logic [1:0]  op_i;
  logic [25:0] jfield_i;
  logic [31:0] pc_o;
  logic [31:0] iar_o;
  logic [31:0] next_pc_o;

  int n_tests;
  int n_fail;

  logic [31:0] m_pc;
  logic [31:0] m_iar;

  trap_pc_unit u_trap_pc_unit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .stall_i   (stall_i),
    .op_i      (op_i),
    .jfield_i  (jfield_i),
    .pc_o      (pc_o),
    .iar_o     (iar_o),
    .next_pc_o (next_pc_o)
  );

  initial clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] op, input logic en);
    if (!en) return "R6";
    case (op)
      2'b00, 2'b01: return "R1";
      2'b10:        return "R2";
      default:      return "R4";
    endcase
  endfunction

  // Drive one cycle at a falling edge and check the result at the next one
  task automatic step(input logic [1:0] op, input logic [25:0] f,
                      input logic v, input logic s);
    logic        en;
    logic [31:0] e_pc;
    logic [31:0] e_iar;
    op_i = op; jfield_i = f; valid_i = v; stall_i = s;
    en    = v && !s;
    e_pc  = m_pc;
    e_iar = m_iar;
    if (en) begin
      case (op)
        2'b00, 2'b01: e_pc = m_pc + 32'd4;
        2'b10: begin e_pc = {6'b0, f}; e_iar = m_pc + 32'd8; end
        default: e_pc = m_iar;
      endcase
    end
    #1;
    check("R8", next_pc_o, e_pc);
    @(negedge clk_i);
    check(req_of(op, en), pc_o, e_pc);
    check((en && op == 2'b10) ? "R3" : "R5", iar_o, e_iar);
    m_pc  = e_pc;
    m_iar = e_iar;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    m_pc = '0; m_iar = '0;
    rst_ni = 1'b0; valid_i = 1'b1; stall_i = 1'b0; op_i = 2'b10; jfield_i = 26'h3ffffff;
    repeat (3) @(negedge clk_i);
    check("R7", pc_o, 32'h0);
    check("R7", iar_o, 32'h0);
    rst_ni = 1'b1;
    // R7: two edges after release still show reset state despite a trap request
    @(negedge clk_i);
    check("R7", pc_o, 32'h0);
    @(negedge clk_i);
    check("R7", pc_o, 32'h0);
    check("R7", iar_o, 32'h0);
    // R2: top field bit set is not sign-extended
    step(2'b10, 26'h2000000, 1'b1, 1'b0);
    check("R2", {26'b0, pc_o[31:26]}, 32'h0);
    // R4: return restores, IAR unchanged
    step(2'b11, 26'h1234567, 1'b1, 1'b0);
    step(2'b01, 26'h0, 1'b1, 1'b0);
    // Near-exhaustive sweep: every class x every enable combination x walking field bits
    for (int b = 0; b < 27; b++) begin
      for (int op = 0; op < 4; op++) begin
        for (int ctl = 0; ctl < 4; ctl++) begin
          logic [25:0] f;
          f = (b == 26) ? 26'h3ffffff : (26'h1 << b);
          if (op[0]) f = ~f;
          step(op[1:0], f, ctl[0] ? 1'b0 : 1'b1, ctl[1]);
        end
      end
    end
    // Trap followed by return sequences at several PCs
    for (int k = 0; k < 64; k++) begin
      step(2'b00, 26'h0, 1'b1, 1'b0);
      step(2'b10, 26'(k * 26'h0a5a5a4), 1'b1, 1'b0);
      step(2'b00, 26'h0, 1'b1, k[0]);
      step(2'b11, 26'h3ffffff, 1'b1, 1'b0);
    end
    // Pseudo-random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[1:0], r[31:6], r[2] | r[3], r[4] & r[5]);
    end
    // R7: asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    check("R7", pc_o, 32'h0);
    check("R7", iar_o, 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule